// File: doc/BRIEF.md
# Boot Sequencer with Firmware-Update Warm Reset

This block walks a security subsystem out of power-on reset. It waits for the host SoC to report good power and to release its active-low reset. It then signals that it is ready to receive fuse values. When the host reports that fuse loading is finished, the block releases the internal reset to the rest of the subsystem. That release goes through a two-flop synchronizer.

Once the subsystem is running, firmware can request a warm reset for a firmware update. The request resets only the embedded microcontroller. Peripherals, bus slaves and memories stay out of reset and keep their contents. During the warm reset the block also sends a single-cycle strobe that unlocks instruction memory, so that new code can be copied in. The microcontroller reset stays asserted for a programmable number of cycles. Its release also goes through a two-flop synchronizer.

All pins are plain control and status signals. No data flows through the block, so there is no valid/ready handshake. The update request is a one-cycle write strobe and behaves as a register bit that clears itself. A current-state output is provided for observation.

Top module: `boot_seq`

## Requirements
- R1: While `pwr_good` is low or `soc_rst_n` is low, the state returns at once to IDLE without waiting for a clock. In that condition `fuse_ready`, `core_rst_n`, `mcu_rst_n` and `iccm_unlock` are all 0. The `state` encoding is IDLE=0, FUSE=1, DONE=2, UPD=3, WAIT=4.
- R2: Once both reset conditions are gone, the first rising clock edge moves the state from IDLE to FUSE.
- R3: `fuse_ready` is 1 exactly while the state is FUSE. The state holds in FUSE until a clock edge samples `fuse_done` high, and that edge moves it to DONE.
- R4: After a cold boot, `core_rst_n` and `mcu_rst_n` both go high on the second rising edge after the edge that entered DONE. Before that edge they are 0.
- R5: An edge that samples `upd_wr` high while the state is DONE moves the state to UPD. A high `upd_wr` in any other state is ignored and leaves the state unchanged.
- R6: `iccm_unlock` is high for exactly one cycle per update, and only during the UPD state.
- R7: Let N be `wait_cycles` with 0 replaced by 1. The WAIT state lasts N cycles and then returns to DONE. `mcu_rst_n` goes low on the second edge after the edge that samples the write, and stays low for exactly N+1 cycles.
- R8: `core_rst_n` stays high for the whole of an update, from the write until the state is back in DONE.
- R9: `wait_cycles` is taken only on entry to UPD. Changing it during WAIT does not change the length of the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Power-good from the SoC; low forces reset |
| soc_rst_n | input | 1 | Active-low SoC reset |
| fuse_done | input | 1 | Register bit: fuse loading finished |
| upd_wr | input | 1 | Write strobe of 1 to the update-reset bit |
| wait_cycles | input | WAIT_W | Programmed hold length of the microcontroller reset |
| fuse_ready | output | 1 | Ready to accept fuse values |
| core_rst_n | output | 1 | Synchronized internal reset for peripherals |
| mcu_rst_n | output | 1 | Synchronized microcontroller-only reset |
| iccm_unlock | output | 1 | One-cycle instruction-memory unlock strobe |
| state | output | 3 | Current sequencer state |

## Verification
The hardest case to reach from the ports is a change of `wait_cycles`, or a loss of power, while the sequencer is part way through WAIT. The bench gets there by starting an update at a known edge and counting edges from it. It then changes the count, or drops `pwr_good` between edges, at a fixed offset into the wait. The wait counts 0 through 12 are swept one after another. For each count, the bench measures the low time of the microcontroller reset, the number of unlock strobes and the peripheral reset, every cycle.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FUSE = 3'd1,
    ST_DONE = 3'd2,
    ST_UPD  = 3'd3,
    ST_WAIT = 3'd4
  } boot_state_e;
endpackage

// File: rtl/boot_rst_sync.sv
// Release synchronizer: asserts asynchronously, releases after STAGES edges.
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rel,
  output logic rst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], rel};
  end

  assign rst_n = q[STAGES-1];
endmodule

// File: rtl/boot_wait_timer.sv
// Down-counter holding the microcontroller reset; zero limit counts as one.
module boot_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                 cnt <= '0;
    else if (load)               cnt <= (limit == '0) ? ONE : limit;
    else if (run && cnt > ONE)   cnt <= cnt - ONE;
  end

  assign expired = run && (cnt == ONE);

  // R7: the counter is never empty while the wait runs
  a_r7_cnt_live: assert property (@(posedge clk) disable iff (!arst_n)
    run |-> (cnt != '0));
  // R9: the count only moves downward while running
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!arst_n)
    (run && !load && $past(run)) |-> (cnt <= $past(cnt)));
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import boot_seq_pkg::*;
(
  input  logic        clk,
  input  logic        arst_n,
  input  logic        fuse_done,
  input  logic        upd_wr,
  input  logic        tmr_expired,
  output boot_state_e st
);
  boot_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: nxt = ST_FUSE;
      ST_FUSE: if (fuse_done) nxt = ST_DONE;
      ST_DONE: if (upd_wr)    nxt = ST_UPD;
      ST_UPD:  nxt = ST_WAIT;
      ST_WAIT: if (tmr_expired) nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st <= ST_IDLE;
    else         st <= nxt;
  end

  // R3: without fuse_done the fuse state holds
  a_r3_fuse_hold: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_FUSE && !fuse_done) |=> (st == ST_FUSE));
  // R5: update writes outside DONE do not start an update
  a_r5_ignore_wr: assert property (@(posedge clk) disable iff (!arst_n)
    (st != ST_DONE) |=> (st != ST_UPD));
  // R6: the update state lasts a single cycle
  a_r6_upd_once: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_UPD) |=> (st == ST_WAIT));
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int WAIT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              soc_rst_n,
  input  logic              fuse_done,
  input  logic              upd_wr,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              fuse_ready,
  output logic              core_rst_n,
  output logic              mcu_rst_n,
  output logic              iccm_unlock,
  output logic [2:0]        state
);
  logic        arst_n;
  boot_state_e st;
  logic        tmr_expired;
  logic        core_rel, mcu_rel;

  assign arst_n = pwr_good & soc_rst_n;

  boot_fsm u_fsm (
    .clk         (clk),
    .arst_n      (arst_n),
    .fuse_done   (fuse_done),
    .upd_wr      (upd_wr),
    .tmr_expired (tmr_expired),
    .st          (st)
  );

  boot_wait_timer #(.W(WAIT_W)) u_tmr (
    .clk     (clk),
    .arst_n  (arst_n),
    .load    (st == ST_UPD),
    .run     (st == ST_WAIT),
    .limit   (wait_cycles),
    .expired (tmr_expired)
  );

  assign core_rel = (st == ST_DONE) || (st == ST_UPD) || (st == ST_WAIT);
  assign mcu_rel  = (st == ST_DONE);

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk (clk), .arst_n (arst_n), .rel (core_rel), .rst_n (core_rst_n)
  );

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_mcu_sync (
    .clk (clk), .arst_n (arst_n), .rel (mcu_rel), .rst_n (mcu_rst_n)
  );

  assign fuse_ready  = (st == ST_FUSE);
  assign iccm_unlock = (st == ST_UPD);
  assign state       = st;

  // R8: peripheral reset never re-asserts without a cold reset
  a_r8_core_steady: assert property (@(posedge clk) disable iff (!arst_n)
    !$fell(core_rst_n));
  // R6: the unlock strobe is never two cycles long
  a_r6_unlock_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    iccm_unlock |=> !iccm_unlock);
  // R7: the microcontroller reset is held while the wait runs
  a_r7_mcu_held: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_WAIT && $past(st) == ST_WAIT) |-> !mcu_rst_n);
  // R4: the microcontroller never leaves reset before the peripherals
  a_r4_order: assert property (@(posedge clk) disable iff (!arst_n)
    mcu_rst_n |-> core_rst_n);
endmodule

// File: tb/boot_seq_test.sv
`timescale 1ns/1ps
module boot_seq_test;
  localparam int WAIT_W = 8;
  logic clk = 1'b0;
  logic pwr_good = 1'b0, soc_rst_n = 1'b0, fuse_done = 1'b0, upd_wr = 1'b0;
  logic [WAIT_W-1:0] wait_cycles = '0;
  logic fuse_ready, core_rst_n, mcu_rst_n, iccm_unlock;
  logic [2:0] state;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boot_seq #(.WAIT_W(WAIT_W)) uut (
    .clk(clk), .pwr_good(pwr_good), .soc_rst_n(soc_rst_n),
    .fuse_done(fuse_done), .upd_wr(upd_wr), .wait_cycles(wait_cycles),
    .fuse_ready(fuse_ready), .core_rst_n(core_rst_n), .mcu_rst_n(mcu_rst_n),
    .iccm_unlock(iccm_unlock), .state(state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Runs one update; new_w (if >=0) replaces wait_cycles two cycles into WAIT.
  task automatic do_update(input int w, input int new_w);
    int n, lows, first_low, unl, waits, core_low;
    n = (w == 0) ? 1 : w;
    lows = 0; first_low = -1; unl = 0; waits = 0; core_low = 0;
    @(negedge clk);
    wait_cycles = WAIT_W'(w);
    upd_wr = 1'b1;
    step();
    upd_wr = 1'b0;
    chk("R5 state after write", state, 3);
    for (int i = 0; i < n + 10; i++) begin
      if (i > 0) step();
      if (i == 3 && new_w >= 0) wait_cycles = WAIT_W'(new_w);
      if (!mcu_rst_n) begin
        lows++;
        if (first_low < 0) first_low = i;
      end
      if (iccm_unlock) unl++;
      if (iccm_unlock && state != 3) unl += 100;
      if (state == 4) waits++;
      if (!core_rst_n) core_low++;
    end
    chk("R6 unlock strobes", unl, 1);
    chk(new_w >= 0 ? "R9 wait length" : "R7 wait length", waits, n);
    chk("R7 mcu low cycles", lows, n + 1);
    chk("R7 mcu low start", first_low, 2);
    chk("R8 core reset lows", core_low, 0);
    chk("R7 back in DONE", state, 2);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 idle state", state, 0);
    chk("R1 fuse_ready", fuse_ready, 0);
    chk("R1 core_rst_n", core_rst_n, 0);
    chk("R1 mcu_rst_n", mcu_rst_n, 0);
    chk("R1 iccm_unlock", iccm_unlock, 0);
    @(negedge clk) pwr_good = 1'b1;
    repeat (2) step();
    chk("R1 soc reset holds idle", state, 0);
    @(negedge clk) soc_rst_n = 1'b1;
    step();
    chk("R2 idle to fuse", state, 1);
    chk("R3 fuse_ready in FUSE", fuse_ready, 1);
    @(negedge clk) upd_wr = 1'b1;
    step();
    upd_wr = 1'b0;
    chk("R5 write ignored in FUSE", state, 1);
    repeat (3) step();
    chk("R3 hold without fuse_done", state, 1);
    chk("R4 core in reset during FUSE", core_rst_n, 0);
    @(negedge clk) fuse_done = 1'b1;
    step();
    chk("R3 fuse to done", state, 2);
    chk("R3 fuse_ready cleared", fuse_ready, 0);
    chk("R4 core low at DONE entry", core_rst_n, 0);
    step();
    chk("R4 core low one edge later", core_rst_n, 0);
    chk("R4 mcu low one edge later", mcu_rst_n, 0);
    step();
    chk("R4 core released", core_rst_n, 1);
    chk("R4 mcu released", mcu_rst_n, 1);
    for (int w = 0; w <= 12; w++) do_update(w, -1);
    do_update(3, 20);
    do_update(9, 1);
    // asynchronous loss of power in the middle of WAIT
    @(negedge clk);
    wait_cycles = WAIT_W'(10);
    upd_wr = 1'b1;
    step();
    upd_wr = 1'b0;
    repeat (3) step();
    chk("R7 in WAIT before power loss", state, 4);
    #3 pwr_good = 1'b0;
    #1;
    chk("R1 async idle", state, 0);
    chk("R1 async core reset", core_rst_n, 0);
    chk("R1 async mcu reset", mcu_rst_n, 0);
    chk("R1 async unlock low", iccm_unlock, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule